// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. Each operation takes a 4-bit operation code, two 8-bit operands `a` and `b`, and the current flag word. It returns an 8-bit result and a new six-bit flag word. The output is purely combinational, so a surrounding pipeline registers the result and the flags wherever its timing requires.

There are eleven operations:

- Add family: add and add with carry.
- Subtract family: subtract, subtract with carry, compare and negate.
- Logic: bitwise AND, OR and XOR.
- Step: increment and decrement of `a`.

One flag bit holds signed overflow after arithmetic and even parity after logic. Two further bits record the half-carry and whether the last operation was a subtraction, so that a later decimal-correction step can use them. A flag that an operation does not define is copied from `flags_in`.

The flag word layout is:

| Bit | Meaning |
|-----|---------|
| 0 | carry |
| 1 | subtract marker |
| 2 | parity/overflow |
| 3 | half-carry |
| 4 | zero |
| 5 | sign |

Top module: `alu8_flags`

## Requirements
- R1: The op codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 negate, 6 AND, 7 OR, 8 XOR, 9 increment, 10 decrement. Add gives `a+b`, and add-with-carry gives `a+b+flags_in[0]`. Both results are taken modulo 256, and carry (bit 0) is set on a carry out of bit 7.
- R2: Subtract gives `a-b`, subtract-with-carry gives `a-b-flags_in[0]`, and negate gives `0-a` (`b` is ignored). All three results are modulo 256, and carry (bit 0) is set when a borrow out of bit 7 occurs.
- R3: Compare returns `a` unchanged on `result`, and its flags equal those of subtract on the same operands.
- R4: For every op code from 0 to 10, zero (bit 4) is 1 exactly when the computed value is 0, and sign (bit 5) copies its bit 7. For compare, the computed value is the difference.
- R5: For the add, subtract and step operations, bit 2 is set on two's-complement overflow of the 8-bit signed result.
- R6: Half-carry (bit 3) is set on a carry from bit 3 into bit 4 for add-type operations. It is set on a borrow into bit 4 for subtract-type operations.
- R7: Subtract marker (bit 1) is 1 after subtract, subtract-with-carry, compare, negate and decrement. It is 0 after add, add-with-carry, increment and all logic operations.
- R8: AND, OR and XOR return the bitwise result and clear carry. Bit 2 is 1 when the result holds an even number of ones. Half-carry is 1 for AND and 0 for OR and XOR.
- R9: Increment and decrement change `a` by one modulo 256 and ignore `b`. The carry bit is copied unchanged from `flags_in[0]`.
- R10: Op codes 11 to 15 return `a` on `result` and copy `flags_in` to `flags_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| a | input | 8 | First operand (accumulator) |
| b | input | 8 | Second operand |
| flags_in | input | 6 | Current flag word |
| result | output | 8 | Operation result |
| flags_out | output | 6 | Updated flag word |

## Verification
Every output is due in the same time step as the inputs that produce it, with no register anywhere on the path. The bench therefore applies each vector and samples the outputs a fraction of a nanosecond later, before the next vector is applied. It never waits on a clock edge for a result. An independent integer model supplies the expected values. The bench sweeps all operand pairs, both incoming carry values for the carry-using operations, a set of hand-worked corner values, and the unused op codes.

// File: rtl/alu8_pkg.sv
`timescale 1ns/10ps
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int FLAG_W = 6;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_NEG = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_kind_e;

    // Bit order: sign, zero, half, parity/overflow, subtract marker, carry
    typedef struct packed {
        logic sgn;
        logic zro;
        logic hlf;
        logic pov;
        logic sub;
        logic cry;
    } alu_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic              sub;
        logic              cin;
    } arith_req_t;

    function automatic logic is_arith(input logic [3:0] code);
        return (code <= 4'd5) || (code == 4'd9) || (code == 4'd10);
    endfunction

    function automatic logic is_logic(input logic [3:0] code);
        return (code >= 4'd6) && (code <= 4'd8);
    endfunction

    function automatic logic is_step(input logic [3:0] code);
        return (code == 4'd9) || (code == 4'd10);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/10ps
module alu8_arith #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              sub,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cry,
    output logic              hlf,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] y_eff;
    logic              c_eff;
    logic [DATA_W:0]   full_sum;
    logic [NIB_W:0]    low_sum;

    always_comb begin
        y_eff    = sub ? ~y : y;
        c_eff    = sub ? ~cin : cin;
        full_sum = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c_eff};
        low_sum  = {1'b0, x[NIB_W-1:0]} + {1'b0, y_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, c_eff};
        res      = full_sum[DATA_W-1:0];
        // a subtraction borrows when the inverted-operand sum does not carry
        cry      = full_sum[DATA_W] ^ sub;
        hlf      = low_sum[NIB_W] ^ sub;
        ovf      = (x[MSB] == y_eff[MSB]) && (res[MSB] != x[MSB]);
    end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/10ps
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic_kind_e       kind,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] res,
    output logic              even
);
    always_comb begin
        unique case (kind)
            LG_AND:  res = x & y;
            LG_OR:   res = x | y;
            default: res = x ^ y;
        endcase
        even = ~(^res);
    end
endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/10ps
module alu8_flags
    import alu8_pkg::*;
(
    input  logic [3:0] op,
    input  logic [7:0] a,
    input  logic [7:0] b,
    input  logic [5:0] flags_in,
    output logic [7:0] result,
    output logic [5:0] flags_out
);
    localparam int NIB_W = DATA_W / 2;

    alu_flags_t        fin;
    alu_flags_t        fout;
    arith_req_t        areq;
    logic_kind_e       lkind;
    logic [DATA_W-1:0] ares;
    logic [DATA_W-1:0] lres;
    logic              a_cry;
    logic              a_hlf;
    logic              a_ovf;
    logic              l_even;

    assign fin = alu_flags_t'(flags_in);

    // operand steering for the shared adder
    always_comb begin
        areq = '{x: a, y: b, sub: 1'b0, cin: 1'b0};
        case (op)
            OP_ADC: areq.cin = fin.cry;
            OP_SUB: areq.sub = 1'b1;
            OP_SBC: begin
                areq.sub = 1'b1;
                areq.cin = fin.cry;
            end
            OP_CMP: areq.sub = 1'b1;
            OP_NEG: areq = '{x: '0, y: a, sub: 1'b1, cin: 1'b0};
            OP_INC: areq.y = DATA_W'(1);
            OP_DEC: begin
                areq.y   = DATA_W'(1);
                areq.sub = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        case (op)
            OP_AND:  lkind = LG_AND;
            OP_OR:   lkind = LG_OR;
            default: lkind = LG_XOR;
        endcase
    end

    alu8_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
        .x   (areq.x),
        .y   (areq.y),
        .sub (areq.sub),
        .cin (areq.cin),
        .res (ares),
        .cry (a_cry),
        .hlf (a_hlf),
        .ovf (a_ovf)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .kind (lkind),
        .x    (a),
        .y    (b),
        .res  (lres),
        .even (l_even)
    );

    // result and flag assembly
    always_comb begin
        result = a;
        fout   = fin;
        if (is_arith(op)) begin
            result   = (op == OP_CMP) ? a : ares;
            fout.sgn = ares[DATA_W-1];
            fout.zro = (ares == '0);
            fout.hlf = a_hlf;
            fout.pov = a_ovf;
            fout.sub = areq.sub;
            fout.cry = is_step(op) ? fin.cry : a_cry;
        end else if (is_logic(op)) begin
            result   = lres;
            fout.sgn = lres[DATA_W-1];
            fout.zro = (lres == '0);
            fout.hlf = (op == OP_AND);
            fout.pov = l_even;
            fout.sub = 1'b0;
            fout.cry = 1'b0;
        end
    end

    assign flags_out = fout;
endmodule

// File: rtl/alu8_flags_chk.sv
`timescale 1ns/10ps
module alu8_flags_chk (
    input logic [3:0] op,
    input logic [7:0] a,
    input logic [7:0] b,
    input logic [5:0] flags_in,
    input logic [7:0] result,
    input logic [5:0] flags_out
);
    always_comb begin
        if (op == 4'd4) begin
            AST_CMP_KEEPS_A: assert (result == a); // R3
        end
        if (op <= 4'd10 && op != 4'd4) begin
            AST_ZERO_MATCH: assert (flags_out[4] == (result == 8'd0)); // R4
            AST_SIGN_MATCH: assert (flags_out[5] == result[7]); // R4
        end
        if (op >= 4'd6 && op <= 4'd8) begin
            AST_LOGIC_CLR: assert (flags_out[0] == 1'b0 && flags_out[1] == 1'b0); // R8
            AST_LOGIC_PAR: assert (flags_out[2] == ~(^result)); // R8
        end
        if (op == 4'd9 || op == 4'd10) begin
            AST_STEP_CARRY: assert (flags_out[0] == flags_in[0]); // R9
        end
        if (op == 4'd2 || op == 4'd3 || op == 4'd4 || op == 4'd5 || op == 4'd10) begin
            AST_SUB_MARK: assert (flags_out[1] == 1'b1); // R7
        end
        if (op >= 4'd11) begin
            AST_UNUSED_PASS: assert (result == a && flags_out == flags_in); // R10
        end
    end
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .op        (op),
    .a         (a),
    .b         (b),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/alu8_flags_test.sv
`timescale 1ns/10ps
module alu8_flags_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [5:0] flags_in;
    logic [7:0] result;
    logic [5:0] flags_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu8_flags uut (
        .op(op), .a(a), .b(b), .flags_in(flags_in),
        .result(result), .flags_out(flags_out)
    );

    function automatic int sgn8(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // independent integer model: returns {result, flags}
    function automatic logic [13:0] model(input int o, input int x, input int y, input logic [5:0] fi);
        int r, sr, ci, ones;
        logic c, n, h, v, z, s;
        logic [7:0] res;
        c = fi[0]; n = fi[1]; v = fi[2]; h = fi[3];
        res = 8'(x);
        ci = 0;
        case (o)
            0, 1: begin
                ci = (o == 1) ? int'(fi[0]) : 0;
                r  = x + y + ci;
                sr = sgn8(x) + sgn8(y) + ci;
                c  = r > 255;
                h  = ((x % 16) + (y % 16) + ci) > 15;
                v  = (sr > 127) || (sr < -128);
                n  = 0;
                res = 8'(r);
            end
            2, 3, 4, 5: begin
                int p, q;
                p  = (o == 5) ? 0 : x;
                q  = (o == 5) ? x : y;
                ci = (o == 3) ? int'(fi[0]) : 0;
                r  = p - q - ci;
                sr = sgn8(p) - sgn8(q) - ci;
                c  = r < 0;
                h  = ((p % 16) - (q % 16) - ci) < 0;
                v  = (sr > 127) || (sr < -128);
                n  = 1;
                res = 8'(r);
            end
            9: begin
                r = x + 1; h = (x % 16) == 15; v = (x == 127); n = 0; res = 8'(r);
            end
            10: begin
                r = x - 1; h = (x % 16) == 0; v = (x == 128); n = 1; res = 8'(r);
            end
            6, 7, 8: begin
                if (o == 6) res = 8'(x) & 8'(y);
                else if (o == 7) res = 8'(x) | 8'(y);
                else res = 8'(x) ^ 8'(y);
                ones = 0;
                for (int i = 0; i < 8; i++) ones += int'(res[i]);
                v = (ones % 2) == 0;
                h = (o == 6);
                c = 0; n = 0;
            end
            default: return {8'(x), fi};
        endcase
        z = (res == 8'd0);
        s = res[7];
        if (o == 4) res = 8'(x);
        return {res, s, z, h, v, n, c};
    endfunction

    task automatic apply_check(input int o, input int x, input int y, input logic [5:0] fi, input string req);
        logic [13:0] exp;
        op = 4'(o); a = 8'(x); b = 8'(y); flags_in = fi;
        #0.05;
        exp = model(o, x, y, fi);
        checks++;
        if ({result, flags_out} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h fin=%02h: got res=%02h flags=%02h, expected res=%02h flags=%02h",
                     req, o, x, y, fi, result, flags_out, exp[13:6], exp[5:0]);
        end
        #0.05;
    endtask

    task automatic test_idle();
        apply_check(0, 0, 0, 6'h00, "R4 idle add of zeros");
    endtask

    task automatic test_add_family();
        for (int o = 0; o <= 1; o++)
            for (int c = 0; c <= o; c++)
                for (int x = 0; x < 256; x++)
                    for (int y = 0; y < 256; y++)
                        apply_check(o, x, y, {6'(x ^ y) & 6'h3E} | 6'(c), "R1 R5 R6 add family");
    endtask

    task automatic test_sub_family();
        for (int o = 2; o <= 3; o++)
            for (int c = 0; c <= o - 2; c++)
                for (int x = 0; x < 256; x++)
                    for (int y = 0; y < 256; y++)
                        apply_check(o, x, y, {6'(x + y) & 6'h3E} | 6'(c), "R2 R5 R6 R7 subtract family");
        for (int x = 0; x < 256; x++)
            apply_check(5, x, 255 - x, 6'h15, "R2 negate");
    endtask

    task automatic test_compare();
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                apply_check(4, x, y, 6'(x) | 6'h01, "R3 compare");
    endtask

    task automatic test_logic();
        for (int o = 6; o <= 8; o++)
            for (int x = 0; x < 256; x++)
                for (int y = 0; y < 256; y++)
                    apply_check(o, x, y, 6'h3F, "R8 logic");
    endtask

    task automatic test_step();
        for (int o = 9; o <= 10; o++)
            for (int c = 0; c <= 1; c++)
                for (int x = 0; x < 256; x++)
                    apply_check(o, x, x ^ 8'hA5, 6'(c) | 6'h2A, "R9 step keeps carry");
    endtask

    task automatic test_unused();
        for (int o = 11; o <= 15; o++)
            for (int x = 0; x < 256; x += 17)
                apply_check(o, x, 255 - x, 6'(x + o), "R10 unused op codes");
    endtask

    task automatic test_corners();
        // hand-worked values, compared against literals
        op = 4'd0; a = 8'h7F; b = 8'h01; flags_in = 6'h00; #0.05;
        checks++;
        if (result !== 8'h80 || flags_out !== 6'h2C) begin
            errors++;
            $display("FAIL R5 7F+01: got %02h/%02h, expected 80/2C", result, flags_out);
        end
        #0.05;
        op = 4'd5; a = 8'h80; b = 8'h00; flags_in = 6'h00; #0.05;
        checks++;
        if (result !== 8'h80 || flags_out !== 6'h27) begin
            errors++;
            $display("FAIL R2 negate 80: got %02h/%02h, expected 80/27", result, flags_out);
        end
        #0.05;
        op = 4'd2; a = 8'h00; b = 8'h01; flags_in = 6'h00; #0.05;
        checks++;
        if (result !== 8'hFF || flags_out !== 6'h2B) begin
            errors++;
            $display("FAIL R6 00-01: got %02h/%02h, expected FF/2B", result, flags_out);
        end
        #0.05;
        op = 4'd4; a = 8'h42; b = 8'h42; flags_in = 6'h00; #0.05;
        checks++;
        if (result !== 8'h42 || flags_out !== 6'h12) begin
            errors++;
            $display("FAIL R3 compare equal: got %02h/%02h, expected 42/12", result, flags_out);
        end
        #0.05;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: got running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op = '0; a = '0; b = '0; flags_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        test_idle();
        test_corners();
        test_add_family();
        test_sub_family();
        test_compare();
        test_logic();
        test_step();
        test_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule